// File: doc/BRIEF.md
# Packed SIMD ALU

This execution unit serves a 32-bit DSP-oriented core. Each operation treats its two 32-bit sources as a vector of either four 8-bit lanes or two 16-bit lanes. The lane size is chosen per operation.

The unit performs the following operations:
- lane-wise wrapping add;
- minimum and maximum;
- equality and less-than masks;
- a shuffle that gathers lanes of the first source by index;
- a pack that interleaves the even lanes of both sources;
- a full-width dot product, optionally accumulated into a third 32-bit operand.

A replicate flag broadcasts the lowest lane of the second source across all lanes before any operation uses it. This gives vector-by-scalar forms of every operation without extra instructions.

The result is computed combinationally and registered once. An operation presented with `valid_i` high returns its result on `result_o` with `valid_o` high one clock later. When `valid_i` is low, the register keeps its last result.

Top module: `simd_alu`

## Requirements
- R1: `valid_o` is high in exactly those cycles that follow a rising clock edge at which `valid_i` was high. During reset `valid_o` is 0 and `result_o` is 0.
- R2: A clock edge with `valid_i` low leaves `result_o` unchanged, whatever the other inputs are.
- R3: Operation kind 0 (`op_i[3:0]`=0) adds the sources lane by lane, modulo 2^lane width, with no carry into the next lane.
- R4: Kinds 1 and 2 return the lane-wise minimum and maximum. `op_i[4]`=1 compares lanes as two's-complement values; `op_i[4]`=0 compares them as unsigned values.
- R5: Kind 3 (equal) and kind 4 (less than, signedness from `op_i[4]`) set every bit of a lane to 1 when the condition holds and to 0 otherwise.
- R6: Kind 5 (shuffle) gives result lane i = lane (b lane i mod number of lanes) of `a_i`.
- R7: Kind 6 (pack) fills the lower half of the result lanes with the even-numbered lanes of `a_i`, in ascending order, and the upper half with the even-numbered lanes of b. With 16-bit lanes the result is {b[15:0], a[15:0]}.
- R8: Kind 7 (dot product) returns the 32-bit wrapped sum of the products of corresponding lanes. Lanes are sign-extended when `op_i[4]`=1 and zero-extended otherwise.
- R9: Kind 8 (accumulating dot product) returns `c_i` plus the kind-7 sum, wrapped to 32 bits.
- R10: With `repl_i`=1, every lane of b equals the lowest lane of `b_i` for all kinds. With `repl_i`=0, b is `b_i`.
- R11: `size_i`=0 selects 8-bit lanes and `size_i`=1 selects 16-bit lanes. Kinds 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | [3:0] operation kind, [4] signed |
| size_i | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| repl_i | input | 1 | Broadcast lowest lane of b_i |
| a_i | input | 32 | First source |
| b_i | input | 32 | Second source |
| c_i | input | 32 | Accumulator source |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after the operation is accepted, because only one register lies between the inputs and `result_o`. The bench drives inputs at the falling edge. At the next falling edge it compares `valid_o` and `result_o` with its reference model, so each result is read half a period after the edge that captured it. Idle cycles with changing inputs are checked the same way: one edge later, the expected output is the held previous result.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    K_ADD   = 4'd0,
    K_MIN   = 4'd1,
    K_MAX   = 4'd2,
    K_CMPEQ = 4'd3,
    K_CMPLT = 4'd4,
    K_SHUF  = 4'd5,
    K_PACK  = 4'd6,
    K_DOTP  = 4'd7,
    K_SDOTP = 4'd8
  } kind_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  input  kind_e        kind_i,
  output logic [W-1:0] res_o
);
  logic signed [W:0] a_x, b_x;
  logic lt, eq;

  assign a_x = {sgn_i & a_i[W-1], a_i};
  assign b_x = {sgn_i & b_i[W-1], b_i};
  assign lt  = a_x < b_x;
  assign eq  = a_i == b_i;

  always_comb begin
    case (kind_i)
      K_ADD:   res_o = a_i + b_i;
      K_MIN:   res_o = lt ? a_i : b_i;
      K_MAX:   res_o = lt ? b_i : a_i;
      K_CMPEQ: res_o = {W{eq}};
      K_CMPLT: res_o = {W{lt}};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_dotp.sv
module simd_dotp #(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  input  logic          sgn_i,
  input  logic          acc_i,
  output logic [DW-1:0] res_o
);
  localparam int PW = 2 * W + 2;

  logic signed [PW-1:0] prod [N];

  for (genvar g = 0; g < N; g++) begin : g_mul
    logic signed [W:0] ax, bx;
    assign ax = {sgn_i & a_i[g*W+W-1], a_i[g*W +: W]};
    assign bx = {sgn_i & b_i[g*W+W-1], b_i[g*W +: W]};
    assign prod[g] = ax * bx;
  end

  always_comb begin
    res_o = acc_i ? c_i : '0;
    for (int i = 0; i < N; i++) res_o = res_o + DW'(prod[i]);
  end
endmodule

// File: rtl/simd_perm.sv
module simd_perm #(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          pack_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    res_o = '0;
    for (int i = 0; i < N; i++) begin
      int src;
      if (pack_i) begin
        src = (i < N / 2) ? 2 * i : 2 * i - N;
        res_o[i*W +: W] = (i < N / 2) ? a_i[src*W +: W] : b_i[src*W +: W];
      end else begin
        src = int'(b_i[i*W +: W]) % N;
        res_o[i*W +: W] = a_i[src*W +: W];
      end
    end
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic              size_i,
  input  logic              repl_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int N8  = DATA_W / 8;
  localparam int N16 = DATA_W / 16;

  kind_e kind;
  logic  sgn, acc, pack;
  logic [DATA_W-1:0] b8, b16;
  logic [DATA_W-1:0] lane8, lane16, dot8, dot16, perm8, perm16;
  logic [DATA_W-1:0] res_d;

  assign kind = kind_e'(op_i[3:0]);
  assign sgn  = op_i[4];
  assign acc  = kind == K_SDOTP;
  assign pack = kind == K_PACK;

  assign b8  = repl_i ? {N8{b_i[7:0]}}   : b_i;
  assign b16 = repl_i ? {N16{b_i[15:0]}} : b_i;

  for (genvar g = 0; g < N8; g++) begin : g_l8
    simd_lane #(.W(8)) u_lane (
      .a_i(a_i[g*8 +: 8]), .b_i(b8[g*8 +: 8]), .sgn_i(sgn), .kind_i(kind),
      .res_o(lane8[g*8 +: 8])
    );
  end

  for (genvar g = 0; g < N16; g++) begin : g_l16
    simd_lane #(.W(16)) u_lane (
      .a_i(a_i[g*16 +: 16]), .b_i(b16[g*16 +: 16]), .sgn_i(sgn), .kind_i(kind),
      .res_o(lane16[g*16 +: 16])
    );
  end

  simd_dotp #(.W(8), .N(N8), .DW(DATA_W)) u_dot8 (
    .a_i(a_i), .b_i(b8), .c_i(c_i), .sgn_i(sgn), .acc_i(acc), .res_o(dot8)
  );
  simd_dotp #(.W(16), .N(N16), .DW(DATA_W)) u_dot16 (
    .a_i(a_i), .b_i(b16), .c_i(c_i), .sgn_i(sgn), .acc_i(acc), .res_o(dot16)
  );
  simd_perm #(.W(8), .N(N8), .DW(DATA_W)) u_perm8 (
    .a_i(a_i), .b_i(b8), .pack_i(pack), .res_o(perm8)
  );
  simd_perm #(.W(16), .N(N16), .DW(DATA_W)) u_perm16 (
    .a_i(a_i), .b_i(b16), .pack_i(pack), .res_o(perm16)
  );

  always_comb begin
    case (kind)
      K_ADD, K_MIN, K_MAX, K_CMPEQ, K_CMPLT: res_d = size_i ? lane16 : lane8;
      K_SHUF, K_PACK:                        res_d = size_i ? perm16 : perm8;
      K_DOTP, K_SDOTP:                       res_d = size_i ? dot16  : dot8;
      default:                               res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [4:0]        op_i,
  input logic              size_i,
  input logic              repl_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R2
  AST_CMP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !size_i && (op_i[3:0] == 4'd3 || op_i[3:0] == 4'd4)) |=>
      ((result_o[7:0] == 8'h00 || result_o[7:0] == 8'hff) &&
       (result_o[15:8] == 8'h00 || result_o[15:8] == 8'hff) &&
       (result_o[23:16] == 8'h00 || result_o[23:16] == 8'hff) &&
       (result_o[31:24] == 8'h00 || result_o[31:24] == 8'hff))); // R5
  AST_ADD_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i && !repl_i && op_i[3:0] == 4'd0) |=>
      result_o[15:0] == $past(a_i[15:0] + b_i[15:0])); // R3
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .size_i(size_i), .repl_i(repl_i), .a_i(a_i), .b_i(b_i),
  .valid_o(valid_o), .result_o(result_o)
);

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        size_i = 1'b0;
  logic        repl_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_vec = 0;
  int n_bad = 0;
  logic        exp_v = 1'b0;
  logic [31:0] exp_r = '0;
  string       exp_tag = "R1";

  always #2 clk_i = ~clk_i;

  simd_alu dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .repl_i(repl_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [31:0] model(logic [4:0] op, logic sz, logic rp,
                                        logic [31:0] a, logic [31:0] b, logic [31:0] c);
    int w = sz ? 16 : 8;
    int n = 32 / w;
    longint mask = (64'd1 << w) - 1;
    longint ar[4], br[4], as[4], bs[4], r[4];
    longint sum;
    logic [31:0] o = '0;
    for (int i = 0; i < n; i++) begin
      ar[i] = longint'((a >> (i * w))) & mask;
      br[i] = rp ? (longint'(b) & mask) : (longint'((b >> (i * w))) & mask);
      as[i] = (op[4] && ((ar[i] >> (w - 1)) & 1) == 1) ? ar[i] - (64'd1 << w) : ar[i];
      bs[i] = (op[4] && ((br[i] >> (w - 1)) & 1) == 1) ? br[i] - (64'd1 << w) : br[i];
    end
    if (op[3:0] == 4'd7 || op[3:0] == 4'd8) begin
      sum = (op[3:0] == 4'd8) ? longint'(c) : 0;
      for (int i = 0; i < n; i++) sum = sum + as[i] * bs[i];
      return sum[31:0];
    end
    for (int i = 0; i < n; i++) begin
      case (op[3:0])
        4'd0: r[i] = ar[i] + br[i];
        4'd1: r[i] = (as[i] < bs[i]) ? ar[i] : br[i];
        4'd2: r[i] = (as[i] < bs[i]) ? br[i] : ar[i];
        4'd3: r[i] = (ar[i] == br[i]) ? mask : 0;
        4'd4: r[i] = (as[i] < bs[i]) ? mask : 0;
        4'd5: r[i] = ar[br[i] % n];
        4'd6: r[i] = (i < n / 2) ? ar[2 * i] : br[2 * i - n];
        default: r[i] = 0;
      endcase
      o = o | (32'(r[i] & mask) << (i * w));
    end
    return o;
  endfunction

  function automatic string tag_of(logic [4:0] op, logic rp);
    if (rp) return "R10";
    case (op[3:0])
      4'd0: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare();
    n_vec++;
    if (valid_o !== exp_v || result_o !== exp_r) begin
      n_bad++;
      $display("FAIL %s: valid=%b result=%h expected valid=%b result=%h",
               exp_tag, valid_o, result_o, exp_v, exp_r);
    end
  endtask

  task automatic step(logic v, logic [4:0] op, logic sz, logic rp,
                      logic [31:0] a, logic [31:0] b, logic [31:0] c, string tag);
    @(negedge clk_i);
    compare();
    valid_i = v; op_i = op; size_i = sz; repl_i = rp; a_i = a; b_i = b; c_i = c;
    exp_v = v;
    if (v) exp_r = model(op, sz, rp, a, b, c);
    exp_tag = tag;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #5;
    exp_tag = "R1";
    compare();
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3 lane wrap, no carry
    step(1, 5'h00, 0, 0, 32'hff80_7fff, 32'h0180_0101, 0, "R3");
    step(1, 5'h00, 1, 0, 32'hffff_8000, 32'h0001_8000, 0, "R3");
    // R4 signed vs unsigned
    step(1, 5'h01, 0, 0, 32'h80_7f_01_ff, 32'h7f_80_02_00, 0, "R4");
    step(1, 5'h11, 0, 0, 32'h80_7f_01_ff, 32'h7f_80_02_00, 0, "R4");
    step(1, 5'h12, 1, 0, 32'h8000_0005, 32'h7fff_0004, 0, "R4");
    step(1, 5'h02, 1, 0, 32'h8000_0005, 32'h7fff_0004, 0, "R4");
    // R5 masks
    step(1, 5'h03, 0, 0, 32'h12_34_56_78, 32'h12_00_56_00, 0, "R5");
    step(1, 5'h14, 0, 0, 32'hff_01_80_00, 32'h00_02_7f_00, 0, "R5");
    step(1, 5'h04, 1, 0, 32'hffff_0001, 32'h0000_0002, 0, "R5");
    // R6 shuffle, index wraps mod lanes
    step(1, 5'h05, 0, 0, 32'hdd_cc_bb_aa, 32'h00_05_02_07, 0, "R6");
    step(1, 5'h05, 1, 0, 32'hbbbb_aaaa, 32'h0000_0003, 0, "R6");
    // R7 pack
    step(1, 5'h06, 0, 0, 32'h44_33_22_11, 32'h88_77_66_55, 0, "R7");
    step(1, 5'h06, 1, 0, 32'h4444_3333, 32'h8888_7777, 0, "R7");
    // R8 dot products
    step(1, 5'h07, 0, 0, 32'hff_ff_ff_ff, 32'hff_ff_ff_ff, 0, "R8");
    step(1, 5'h17, 0, 0, 32'hff_80_02_03, 32'h01_80_04_05, 0, "R8");
    step(1, 5'h17, 1, 0, 32'h8000_8000, 32'h8000_8000, 0, "R8");
    step(1, 5'h07, 1, 0, 32'hffff_ffff, 32'hffff_ffff, 0, "R8");
    // R9 accumulate with wrap
    step(1, 5'h08, 0, 0, 32'h01_02_03_04, 32'h05_06_07_08, 32'hffff_fff0, "R9");
    step(1, 5'h18, 1, 0, 32'hffff_0002, 32'h0003_0004, 32'h0000_0100, "R9");
    // R10 replicate
    step(1, 5'h00, 0, 1, 32'h10_20_30_40, 32'h99_88_77_01, 0, "R10");
    step(1, 5'h06, 1, 1, 32'h4444_3333, 32'h8888_7777, 0, "R10");
    step(1, 5'h07, 0, 1, 32'h01_02_03_04, 32'hff_ff_ff_02, 0, "R10");
    // R11 unused kinds
    step(1, 5'h09, 0, 0, 32'hffff_ffff, 32'hffff_ffff, 32'h1, "R11");
    step(1, 5'h1f, 1, 1, 32'h1234_5678, 32'h9abc_def0, 32'h1, "R11");
    // R2 idle cycles hold the result
    step(1, 5'h00, 0, 0, 32'h01_01_01_01, 32'h01_01_01_01, 0, "R2");
    step(0, 5'h07, 1, 0, 32'hffff_ffff, 32'h1234_5678, 32'h5, "R2");
    step(0, 5'h06, 0, 1, 32'h5555_5555, 32'haaaa_aaaa, 32'h5, "R2");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] op;
      logic v, sz, rp;
      op = 5'($urandom_range(0, 31));
      if (op[3:0] > 4'd9) op[3:0] = 4'($urandom_range(0, 8));
      v  = ($urandom_range(0, 7) != 0);
      sz = 1'($urandom);
      rp = ($urandom_range(0, 3) == 0);
      step(v, op, sz, rp, $urandom, $urandom, $urandom, v ? tag_of(op, rp) : "R2");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk_i);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule